// File: doc/BRIEF.md
# Multiplexer-Steered Programmable ALU

This block is a purely combinational arithmetic and logic unit for two `WIDTH`-bit operands. Each result bit of the logic path comes from a 4-to-1 multiplexer. Its select lines are the two operand bits at that position. Its four data inputs are a 4-bit function code, so any two-input Boolean function can be chosen per operation.

Arithmetic runs through one ripple adder. The adder is fed by a pair of operand multiplexers:
- The first adder input is A, ~A, or A shifted left by one with the carry input entering at bit 0.
- The second adder input is B, ~B, all zeros or all ones.

From this shared path the unit produces:
- add with carry, increment and two's complement;
- subtract with borrow and decrement;
- one step of a shift-and-add multiply;
- one step of a restoring divide.

A sequencer outside the block supplies operands and collects results once per step.

An equality flag is produced in every operation. It is built from a second copy of the per-bit multiplexer array hard-wired to the EQV code, followed by an AND reduction. The flag is therefore available alongside any arithmetic result in the same evaluation.

Top module: `palu_top`

## Requirements
- R1: With `op`=0 (logic), result bit i equals `fcode[{a[i],b[i]}]`, where index 3 is `a[i]=1,b[i]=1`. The codes are AND=1000, OR=1110, XOR=0110, EQV=1001, pass A=1100, invert B=0101. `cout` is 0.
- R2: With `op`=1 (add), `{cout,y}` equals `a + b + cin`.
- R3: With `op`=2 (increment), `{cout,y}` equals `a + 1`. `cin` has no effect.
- R4: With `op`=3 (subtract), `y` equals `a - b - cin` modulo 2^WIDTH. `cout` is the borrow-out: 1 exactly when `a < b + cin`.
- R5: With `op`=4 (decrement), `y` equals `a - 1` modulo 2^WIDTH, and `cout` is 1 exactly when `a` is 0. `cin` has no effect.
- R6: With `op`=5 (one's complement), `y` equals `~a` and `cout` is 0.
- R7: With `op`=6 (two's complement), `y` equals `-a` modulo 2^WIDTH, and `cout` is 1 exactly when `a` is 0.
- R8: With `op`=7 (multiply step), let s = `a + (cin ? b : 0)` computed in WIDTH+1 bits. Then `y` equals `s[WIDTH:1]` and `cout` equals `s[0]`.
- R9: With `op`=8 (divide step), let t = `{a, cin}` in WIDTH+1 bits. If t ≥ `b`, then `y` is the low WIDTH bits of t − `b` and `cout` is 1. Otherwise `y` is the low WIDTH bits of t and `cout` is 0.
- R10: `eq` is 1 exactly when `a` equals `b`, under every `op` value.
- R11: For `op` values 9 to 15, `y` and `cout` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand; partial product or partial remainder in step operations |
| b | input | WIDTH | Second operand; multiplicand or divisor in step operations |
| cin | input | 1 | Carry-in, borrow-in, multiplier bit or remainder shift-in bit, depending on `op` |
| op | input | 4 | Operation select |
| fcode | input | 4 | Truth table for the logic operation |
| y | output | WIDTH | Result |
| cout | output | 1 | Carry-out, borrow-out, shifted-out product bit or quotient bit |
| eq | output | 1 | Operands equal |

## Verification
The equality flag and the subtract borrow can both be active in one evaluation. The bench provokes this by subtracting equal operands with and without borrow-in. The result must then be zero with no borrow, or all ones with a borrow, while `eq` stays 1.

The same overlap is exercised in the divide step with equal operands, and in a sweep of every operation code over corner operands. In the sweep, `y`, `cout` and `eq` are each judged against a reference model written from the requirements.

// File: rtl/palu_pkg.sv
package palu_pkg;

    typedef enum logic [3:0] {
        OP_LOGIC = 4'd0,
        OP_ADD   = 4'd1,
        OP_INC   = 4'd2,
        OP_SUB   = 4'd3,
        OP_DEC   = 4'd4,
        OP_ONES  = 4'd5,
        OP_TWOS  = 4'd6,
        OP_MULS  = 4'd7,
        OP_DIVS  = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        XS_A    = 2'd0,
        XS_NOTA = 2'd1,
        XS_SHL  = 2'd2
    } xsel_e;

    typedef enum logic [1:0] {
        YS_B    = 2'd0,
        YS_NOTB = 2'd1,
        YS_ZERO = 2'd2,
        YS_ONES = 2'd3
    } ysel_e;

    typedef enum logic [2:0] {
        RS_ZERO  = 3'd0,
        RS_LOGIC = 3'd1,
        RS_SUM   = 3'd2,
        RS_SHR   = 3'd3,
        RS_RESTO = 3'd4
    } rsel_e;

    typedef struct packed {
        xsel_e xsel;
        ysel_e ysel;
        logic  c0;
        logic  c0_from_cin;
        logic  c0_inv_cin;
        logic  y_gate_cin;
        logic  cout_inv;
        rsel_e rsel;
        logic  force_ones;
    } ctrl_t;

    localparam logic [3:0] FC_EQV  = 4'b1001;
    localparam logic [3:0] FC_NOTA = 4'b0011;

    function automatic ctrl_t decode(input logic [3:0] op);
        ctrl_t c;
        c = '{xsel: XS_A, ysel: YS_ZERO, c0: 1'b0, c0_from_cin: 1'b0,
              c0_inv_cin: 1'b0, y_gate_cin: 1'b0, cout_inv: 1'b0,
              rsel: RS_ZERO, force_ones: 1'b0};
        case (op)
            OP_LOGIC: c.rsel = RS_LOGIC;
            OP_ADD: begin
                c.ysel = YS_B; c.c0_from_cin = 1'b1; c.rsel = RS_SUM;
            end
            OP_INC: begin
                c.ysel = YS_ZERO; c.c0 = 1'b1; c.rsel = RS_SUM;
            end
            OP_SUB: begin
                c.ysel = YS_NOTB; c.c0_inv_cin = 1'b1; c.cout_inv = 1'b1;
                c.rsel = RS_SUM;
            end
            OP_DEC: begin
                c.ysel = YS_ONES; c.cout_inv = 1'b1; c.rsel = RS_SUM;
            end
            OP_ONES: begin
                c.rsel = RS_LOGIC; c.force_ones = 1'b1;
            end
            OP_TWOS: begin
                c.xsel = XS_NOTA; c.ysel = YS_ZERO; c.c0 = 1'b1; c.rsel = RS_SUM;
            end
            OP_MULS: begin
                c.ysel = YS_B; c.y_gate_cin = 1'b1; c.rsel = RS_SHR;
            end
            OP_DIVS: begin
                c.xsel = XS_SHL; c.ysel = YS_NOTB; c.c0 = 1'b1; c.rsel = RS_RESTO;
            end
            default: c.rsel = RS_ZERO;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/palu_logic_array.sv
module palu_logic_array #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       code,
    output logic [WIDTH-1:0] f
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic [1:0] sel;
        assign sel = {a[i], b[i]};
        always_comb begin
            case (sel)
                2'b00:   f[i] = code[0];
                2'b01:   f[i] = code[1];
                2'b10:   f[i] = code[2];
                default: f[i] = code[3];
            endcase
        end
    end
endmodule

// File: rtl/palu_operand_mux.sv
module palu_operand_mux
    import palu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  ctrl_t            ctl,
    output logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] y,
    output logic             c0
);
    logic [WIDTH-1:0] y_raw;

    always_comb begin
        case (ctl.xsel)
            XS_NOTA: x = ~a;
            XS_SHL:  x = {a[WIDTH-2:0], cin};
            default: x = a;
        endcase
    end

    always_comb begin
        case (ctl.ysel)
            YS_B:    y_raw = b;
            YS_NOTB: y_raw = ~b;
            YS_ONES: y_raw = '1;
            default: y_raw = '0;
        endcase
        y = (ctl.y_gate_cin && !cin) ? '0 : y_raw;
    end

    always_comb begin
        if (ctl.c0_from_cin)     c0 = cin;
        else if (ctl.c0_inv_cin) c0 = ~cin;
        else                     c0 = ctl.c0;
    end
endmodule

// File: rtl/palu_adder.sv
module palu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             c0,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] c;
    assign c[0] = c0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        logic p;
        logic g;
        assign p        = x[i] ^ y[i];
        assign g        = x[i] & y[i];
        assign sum[i]   = p ^ c[i];
        assign c[i+1]   = g | (p & c[i]);
    end

    assign cout = c[WIDTH];
endmodule

// File: rtl/palu_top.sv
module palu_top
    import palu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic [3:0]       op,
    input  logic [3:0]       fcode,
    output logic [WIDTH-1:0] y,
    output logic             cout,
    output logic             eq
);
    localparam int MSB = WIDTH - 1;

    ctrl_t            ctl;
    logic [3:0]       lcode;
    logic [WIDTH-1:0] lres;
    logic [WIDTH-1:0] xnor_v;
    logic [WIDTH-1:0] opx;
    logic [WIDTH-1:0] opy;
    logic             c0;
    logic [WIDTH-1:0] sum;
    logic             carry;
    logic             qbit;

    assign ctl   = decode(op);
    assign lcode = ctl.force_ones ? FC_NOTA : fcode;

    palu_logic_array #(.WIDTH(WIDTH)) u_logic (
        .a(a), .b(b), .code(lcode), .f(lres)
    );

    palu_logic_array #(.WIDTH(WIDTH)) u_cmp (
        .a(a), .b(b), .code(FC_EQV), .f(xnor_v)
    );

    assign eq = &xnor_v;

    palu_operand_mux #(.WIDTH(WIDTH)) u_opmux (
        .a(a), .b(b), .cin(cin), .ctl(ctl), .x(opx), .y(opy), .c0(c0)
    );

    palu_adder #(.WIDTH(WIDTH)) u_add (
        .x(opx), .y(opy), .c0(c0), .sum(sum), .cout(carry)
    );

    // quotient bit: shifted-out MSB plus carry means {a,cin} >= b
    assign qbit = a[MSB] | carry;

    always_comb begin
        case (ctl.rsel)
            RS_LOGIC: begin y = lres; cout = 1'b0; end
            RS_SUM:   begin y = sum; cout = carry ^ ctl.cout_inv; end
            RS_SHR:   begin y = {carry, sum[MSB:1]}; cout = sum[0]; end
            RS_RESTO: begin y = qbit ? sum : opx; cout = qbit; end
            default:  begin y = '0; cout = 1'b0; end
        endcase
    end

    // Assertions next to the result path
    always_comb begin
        a_r10_eq_flag: assert (eq == (a == b))
            else $error("R10 eq flag disagrees with operand compare");
        if (op > 4'd8) begin
            a_r11_reserved_zero: assert (y == '0 && cout == 1'b0)
                else $error("R11 reserved op produced nonzero output");
        end
        if (op == OP_ONES) begin
            a_r6_ones: assert ((y ^ a) == '1 && !cout)
                else $error("R6 one's complement mismatch");
        end
        if (op == OP_SUB && eq) begin
            a_r4_sub_equal: assert (cin ? (y == '1 && cout) : (y == '0 && !cout))
                else $error("R4 equal-operand subtract mismatch");
        end
        if (op == OP_DIVS && !cout) begin
            a_r9_restore: assert (y == {a[MSB-1:0], cin})
                else $error("R9 restore did not return shifted remainder");
        end
        if (op == OP_LOGIC) begin
            a_r1_no_carry: assert (!cout)
                else $error("R1 logic op raised cout");
        end
    end
endmodule

// File: tb/tb_palu_top.sv
module tb_palu_top;
    localparam int W = 8;
    localparam int NV = 30;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [3:0]   op = 4'd0;
    logic [3:0]   fcode = 4'd0;
    logic [W-1:0] y;
    logic         cout;
    logic         eq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    palu_top #(.WIDTH(W)) dut (
        .a(a), .b(b), .cin(cin), .op(op), .fcode(fcode),
        .y(y), .cout(cout), .eq(eq)
    );

    // {op, fcode, a, b, cin, exp_y, exp_cout}
    localparam logic [33:0] TBL [NV] = '{
        {4'd0, 4'b1000, 8'hCC, 8'hAA, 1'b0, 8'h88, 1'b0},
        {4'd0, 4'b0110, 8'hCC, 8'hAA, 1'b0, 8'h66, 1'b0},
        {4'd0, 4'b1001, 8'hCC, 8'hAA, 1'b0, 8'h99, 1'b0},
        {4'd0, 4'b1110, 8'hCC, 8'hAA, 1'b0, 8'hEE, 1'b0},
        {4'd0, 4'b1100, 8'hCC, 8'hAA, 1'b1, 8'hCC, 1'b0},
        {4'd0, 4'b0101, 8'hCC, 8'hAA, 1'b0, 8'h55, 1'b0},
        {4'd1, 4'h0, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},
        {4'd1, 4'h0, 8'h12, 8'h34, 1'b1, 8'h47, 1'b0},
        {4'd2, 4'h0, 8'hFF, 8'h12, 1'b1, 8'h00, 1'b1},
        {4'd2, 4'h0, 8'h7F, 8'h00, 1'b0, 8'h80, 1'b0},
        {4'd3, 4'h0, 8'h50, 8'h20, 1'b0, 8'h30, 1'b0},
        {4'd3, 4'h0, 8'h20, 8'h50, 1'b1, 8'hCF, 1'b1},
        {4'd3, 4'h0, 8'h5A, 8'h5A, 1'b0, 8'h00, 1'b0},
        {4'd3, 4'h0, 8'h5A, 8'h5A, 1'b1, 8'hFF, 1'b1},
        {4'd4, 4'h0, 8'h00, 8'h33, 1'b0, 8'hFF, 1'b1},
        {4'd4, 4'h0, 8'h80, 8'h00, 1'b1, 8'h7F, 1'b0},
        {4'd5, 4'h0, 8'h3C, 8'h3C, 1'b1, 8'hC3, 1'b0},
        {4'd6, 4'h0, 8'h01, 8'h00, 1'b0, 8'hFF, 1'b0},
        {4'd6, 4'h0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1},
        {4'd6, 4'h0, 8'h80, 8'h11, 1'b1, 8'h80, 1'b0},
        {4'd7, 4'h0, 8'h0F, 8'hF0, 1'b1, 8'h7F, 1'b1},
        {4'd7, 4'h0, 8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b0},
        {4'd7, 4'h0, 8'h05, 8'hFF, 1'b0, 8'h02, 1'b1},
        {4'd8, 4'h0, 8'h03, 8'h05, 1'b1, 8'h02, 1'b1},
        {4'd8, 4'h0, 8'h02, 8'h07, 1'b0, 8'h04, 1'b0},
        {4'd8, 4'h0, 8'h80, 8'hFF, 1'b0, 8'h01, 1'b1},
        {4'd8, 4'h0, 8'h44, 8'h44, 1'b0, 8'h44, 1'b1},
        {4'd9, 4'hF, 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b0},
        {4'd15, 4'hF, 8'hA5, 8'h5A, 1'b1, 8'h00, 1'b0},
        {4'd12, 4'h6, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0}
    };

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R11";
        endcase
    endfunction

    // Reference model written from the requirements
    task automatic model(input logic [3:0] o, input logic [3:0] fc,
                         input logic [W-1:0] ra, input logic [W-1:0] rb,
                         input logic rc, output logic [W-1:0] ey,
                         output logic ec);
        logic [W:0] t;
        ey = '0; ec = 1'b0;
        case (o)
            4'd0: for (int i = 0; i < W; i++) ey[i] = fc[{ra[i], rb[i]}];
            4'd1: {ec, ey} = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
            4'd2: {ec, ey} = {1'b0, ra} + 1;
            4'd3: begin
                ey = ra - rb - {{(W-1){1'b0}}, rc};
                ec = ({1'b0, ra} < ({1'b0, rb} + {{W{1'b0}}, rc}));
            end
            4'd4: begin ey = ra - 1; ec = (ra == '0); end
            4'd5: ey = ~ra;
            4'd6: begin ey = '0 - ra; ec = (ra == '0); end
            4'd7: begin
                t = {1'b0, ra} + (rc ? {1'b0, rb} : '0);
                ey = t[W:1]; ec = t[0];
            end
            4'd8: begin
                t = {ra, rc};
                if (t >= {1'b0, rb}) begin
                    t = t - {1'b0, rb}; ey = t[W-1:0]; ec = 1'b1;
                end else begin
                    ey = t[W-1:0]; ec = 1'b0;
                end
            end
            default: begin ey = '0; ec = 1'b0; end
        endcase
    endtask

    task automatic check(input string req, input string what,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: op=%0d a=%h b=%h cin=%b actual=%h expected=%h",
                     req, what, op, a, b, cin, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [3:0] fc,
                         input logic [W-1:0] ra, input logic [W-1:0] rb,
                         input logic rc);
        @(negedge clk);
        op = o; fcode = fc; a = ra; b = rb; cin = rc;
        #1;
    endtask

    task automatic run_model(input logic [3:0] o, input logic [3:0] fc,
                             input logic [W-1:0] ra, input logic [W-1:0] rb,
                             input logic rc);
        logic [W-1:0] ey;
        logic         ec;
        apply(o, fc, ra, rb, rc);
        model(o, fc, ra, rb, rc, ey, ec);
        check(req_of(o), "y", y, ey);
        check(req_of(o), "cout", {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, ec});
        check("R10", "eq", {{(W-1){1'b0}}, eq}, {{(W-1){1'b0}}, ra == rb});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] corners [4];
        logic [3:0]   fcs [4];
        corners = '{8'h00, 8'hFF, 8'h80, 8'h5A};
        fcs     = '{4'b1000, 4'b1110, 4'b0110, 4'b1001};

        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset-state check: zero inputs, logic op with code 0
        #1;
        check("R1", "reset y", y, '0);
        check("R10", "reset eq", {{(W-1){1'b0}}, eq}, {{(W-1){1'b0}}, 1'b1});

        // Table walk
        for (int k = 0; k < NV; k++) begin
            logic [33:0] v;
            v = TBL[k];
            apply(v[33:30], v[29:26], v[25:18], v[17:10], v[9]);
            check(req_of(v[33:30]), "tbl y", y, v[8:1]);
            check(req_of(v[33:30]), "tbl cout",
                  {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, v[0]});
            check("R10", "tbl eq", {{(W-1){1'b0}}, eq},
                  {{(W-1){1'b0}}, v[25:18] == v[17:10]});
        end

        // Cin has no effect on increment (R3) and decrement (R5)
        apply(4'd2, 4'h0, 8'h41, 8'h00, 1'b1);
        check("R3", "inc cin ignored", y, 8'h42);
        apply(4'd4, 4'h0, 8'h41, 8'h00, 1'b1);
        check("R5", "dec cin ignored", y, 8'h40);

        // Sweep every op code over corner operands
        for (int o = 0; o < 16; o++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 4; j++) begin
                    for (int c = 0; c < 2; c++) begin
                        run_model(4'(o), fcs[(i + j) % 4], corners[i], corners[j], 1'(c));
                    end
                end
            end
        end

        // Random operands
        for (int n = 0; n < 400; n++) begin
            run_model(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                      8'($urandom), 8'($urandom), 1'($urandom_range(0, 1)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule